// File: doc/BRIEF.md
# Output Protection Fault Supervisor

This block decides, every clock cycle and for each of eight output drivers, whether that driver is allowed to turn on. It watches eight overcurrent comparator flags, one per channel, plus a digital die-temperature code and a digital logic-supply code. It also watches an enable/reset pin and a synchronous power-on reset. The analog comparators and converters sit outside the block, and their results arrive here as plain digital inputs.

An overcurrent flag must stay high for a minimum time before it counts. That time is 2 µs by default, and the number of clock cycles is derived from a clock-frequency parameter. Once an overcurrent is accepted, the block latches a fault for that channel alone. The fault holds until power-on reset or until the enable/reset pin goes high. Thermal shutdown and undervoltage lockout act on all channels at once. They are level based, each has its own hysteresis band, and neither is latched. While the enable/reset pin is high, every channel is held off.

Top module: `prot_fault_supervisor`

## Requirements
- R1: While and after power-on reset (`rst` high), `fault` is 0, `tsd` is 0, `uvlo` is 1 and `allow` is 0.
- R2: An overcurrent flag that stays high for fewer than TRIP_CYC consecutive clock samples never sets the channel's fault. TRIP_CYC is 100 at the defaults: 2 µs at 50 MHz.
- R3: The fault bit sets on the clock edge that samples the TRIP_CYC-th consecutive high flag. Bit i of `fault` belongs to channel i (`oc_flag[i]`), and no other channel's bit changes.
- R4: A single low sample of the flag restarts the channel's count, so separated short pulses do not add up to a trip.
- R5: A latched fault stays set after its flag drops, until `rst` or `en_rst` is high.
- R6: On the edge that samples `en_rst` high, all faults clear. Overcurrent counting is held off while `en_rst` is high, and `allow` is 0 while `en_rst` is high.
- R7: `tsd` sets on the edge that samples `temp_code` above 165, and clears on the edge that samples `temp_code` at 155 or below. Between those values it holds.
- R8: `uvlo` sets on the edge that samples `vdd_code` below 76, and clears on the edge that samples `vdd_code` above 86. Between those values it holds. The code is in 50 mV steps, so 76 is 3.8 V and 86 is 4.3 V.
- R9: `allow[i]` is 1 exactly when `fault[i]`, `tsd`, `uvlo` and `en_rst` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| oc_flag | input | 8 | Overcurrent comparator flags, one per channel |
| temp_code | input | 8 | Die temperature reading, unsigned, in °C |
| vdd_code | input | 8 | Logic supply reading, unsigned, in 50 mV steps |
| en_rst | input | 1 | Enable/reset: high disables all outputs and clears latched faults |
| allow | output | 8 | Per-channel permission to turn the driver on |
| tsd | output | 1 | Thermal shutdown active |
| uvlo | output | 1 | Undervoltage lockout active |
| fault | output | 8 | Latched overcurrent faults, one per channel |

## Verification
The bench applies overcurrent pulses one sample short of the trip count and pulses exactly at it. It also applies pulses of 1.9 µs and 2.1 µs. An off-by-one deglitch counter would either trip on the short pulse or miss the exact one. The bench splits a long overcurrent with a single low sample, which catches a counter that accumulates instead of restarting. It holds `en_rst` high while an overcurrent persists, which catches a design that latches a fault during reset or resumes a stale count afterwards. Temperature and supply ramps step through each hysteresis band, so a comparison with the wrong edge or a missing hold region shows up as the flag toggling at the wrong code.

// File: rtl/prot_sup_pkg.sv
package prot_sup_pkg;

    // Which side of the band asserts the flag
    typedef enum logic {
        HYS_TRIP_ABOVE = 1'b0,
        HYS_TRIP_BELOW = 1'b1
    } hys_dir_e;

    // Conditions that switch every channel off together
    typedef struct packed {
        logic thermal;
        logic undervolt;
        logic pin_hold;
    } global_off_t;

    // Clock cycles covering a duration, rounded up
    function automatic int unsigned cycles_for_ns(longint unsigned clk_hz,
                                                  longint unsigned dur_ns);
        longint unsigned prod;
        prod = clk_hz * dur_ns + 64'd999_999_999;
        return int'(prod / 64'd1_000_000_000);
    endfunction

    // Bits needed to hold the values 0 .. n
    function automatic int unsigned cnt_bits(int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic logic any_off(global_off_t g);
        return g.thermal | g.undervolt | g.pin_hold;
    endfunction

endpackage

// File: rtl/prot_oc_channel.sv
module prot_oc_channel #(
    parameter int unsigned TRIP_CYC = 100,
    localparam int unsigned CW = prot_sup_pkg::cnt_bits(TRIP_CYC)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic oc_flag,
    output logic fault
);
    localparam logic [CW-1:0] LAST = CW'(TRIP_CYC - 1);

    logic [CW-1:0] run_q;
    logic          hit;

    // Flag high on the sample that completes the run
    assign hit = oc_flag && (run_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            run_q <= '0;
            fault <= 1'b0;
        end else begin
            if (!oc_flag) begin
                run_q <= '0;
            end else if (run_q != LAST) begin
                run_q <= run_q + 1'b1;
            end
            if (hit) begin
                fault <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/prot_hyst_flag.sv
module prot_hyst_flag #(
    parameter int unsigned           W       = 8,
    parameter int unsigned           SET_LVL = 165,
    parameter int unsigned           CLR_LVL = 155,
    parameter prot_sup_pkg::hys_dir_e DIR    = prot_sup_pkg::HYS_TRIP_ABOVE,
    parameter logic                  RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] code,
    output logic         flag
);
    localparam logic [W-1:0] SET_C = W'(SET_LVL);
    localparam logic [W-1:0] CLR_C = W'(CLR_LVL);

    logic set_c;
    logic clr_c;

    generate
        if (DIR == prot_sup_pkg::HYS_TRIP_ABOVE) begin : g_above
            assign set_c = code > SET_C;
            assign clr_c = code <= CLR_C;
        end else begin : g_below
            assign set_c = code < SET_C;
            assign clr_c = code > CLR_C;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= RST_VAL;
        end else if (set_c) begin
            flag <= 1'b1;
        end else if (clr_c) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/prot_allow_mask.sv
module prot_allow_mask #(
    parameter int unsigned NCH = 8
) (
    input  logic [NCH-1:0]            fault,
    input  prot_sup_pkg::global_off_t off,
    output logic [NCH-1:0]            allow
);
    logic kill;

    assign kill = prot_sup_pkg::any_off(off);

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            assign allow[i] = !fault[i] && !kill;
        end
    endgenerate
endmodule

// File: rtl/prot_fault_supervisor.sv
module prot_fault_supervisor #(
    parameter int unsigned NCH        = 8,
    parameter longint unsigned CLK_HZ = 50_000_000,
    parameter int unsigned MIN_OC_NS  = 2000,
    parameter int unsigned TEMP_W     = 8,
    parameter int unsigned TEMP_TRIP  = 165,
    parameter int unsigned TEMP_REL   = 155,
    parameter int unsigned VDD_W      = 8,
    parameter int unsigned UV_LOCK    = 76,
    parameter int unsigned UV_RELEASE = 86
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    oc_flag,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic [VDD_W-1:0]  vdd_code,
    input  logic              en_rst,
    output logic [NCH-1:0]    allow,
    output logic              tsd,
    output logic              uvlo,
    output logic [NCH-1:0]    fault
);
    import prot_sup_pkg::*;

    localparam int unsigned TRIP_CYC_RAW = cycles_for_ns(CLK_HZ, longint'(MIN_OC_NS));
    localparam int unsigned TRIP_CYC     = (TRIP_CYC_RAW < 1) ? 1 : TRIP_CYC_RAW;

    global_off_t off;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_oc
            prot_oc_channel #(
                .TRIP_CYC(TRIP_CYC)
            ) oc_i (
                .clk    (clk),
                .rst    (rst),
                .clr    (en_rst),
                .oc_flag(oc_flag[i]),
                .fault  (fault[i])
            );
        end
    endgenerate

    prot_hyst_flag #(
        .W      (TEMP_W),
        .SET_LVL(TEMP_TRIP),
        .CLR_LVL(TEMP_REL),
        .DIR    (HYS_TRIP_ABOVE),
        .RST_VAL(1'b0)
    ) therm_i (
        .clk (clk),
        .rst (rst),
        .code(temp_code),
        .flag(tsd)
    );

    prot_hyst_flag #(
        .W      (VDD_W),
        .SET_LVL(UV_LOCK),
        .CLR_LVL(UV_RELEASE),
        .DIR    (HYS_TRIP_BELOW),
        .RST_VAL(1'b1)
    ) uv_i (
        .clk (clk),
        .rst (rst),
        .code(vdd_code),
        .flag(uvlo)
    );

    assign off.thermal   = tsd;
    assign off.undervolt = uvlo;
    assign off.pin_hold  = en_rst;

    prot_allow_mask #(
        .NCH(NCH)
    ) mask_i (
        .fault(fault),
        .off  (off),
        .allow(allow)
    );
endmodule

// File: rtl/prot_fault_supervisor_chk.sv
module prot_fault_supervisor_chk #(
    parameter int unsigned NCH        = 8,
    parameter int unsigned TEMP_W     = 8,
    parameter int unsigned TEMP_TRIP  = 165,
    parameter int unsigned TEMP_REL   = 155,
    parameter int unsigned VDD_W      = 8,
    parameter int unsigned UV_LOCK    = 76,
    parameter int unsigned UV_RELEASE = 86
) (
    input logic              clk,
    input logic              rst,
    input logic [NCH-1:0]    oc_flag,
    input logic [TEMP_W-1:0] temp_code,
    input logic [VDD_W-1:0]  vdd_code,
    input logic              en_rst,
    input logic [NCH-1:0]    allow,
    input logic              tsd,
    input logic              uvlo,
    input logic [NCH-1:0]    fault
);
    // R5
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en_rst |=> ((fault & $past(fault)) == $past(fault)));

    // R6
    pin_clears_chk: assert property (@(posedge clk) disable iff (rst)
        en_rst |=> (fault == '0));

    // R3
    fault_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ##1 ((fault & ~$past(fault) & ~$past(oc_flag)) == '0));

    // R9
    faulted_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (allow & fault) == '0);

    // R9
    global_off_chk: assert property (@(posedge clk) disable iff (rst)
        (tsd || uvlo || en_rst) |-> (allow == '0));

    // R7
    tsd_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ##1 $rose(tsd) |-> ($past(temp_code) > TEMP_W'(TEMP_TRIP)));

    // R7
    tsd_fall_chk: assert property (@(posedge clk) disable iff (rst)
        ##1 $fell(tsd) |-> ($past(temp_code) <= TEMP_W'(TEMP_REL)));

    // R8
    uvlo_fall_chk: assert property (@(posedge clk) disable iff (rst)
        ##1 $fell(uvlo) |-> ($past(vdd_code) > VDD_W'(UV_RELEASE)));

    // R8
    uvlo_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ##1 $rose(uvlo) |-> ($past(vdd_code) < VDD_W'(UV_LOCK)));
endmodule

bind prot_fault_supervisor prot_fault_supervisor_chk #(
    .NCH       (NCH),
    .TEMP_W    (TEMP_W),
    .TEMP_TRIP (TEMP_TRIP),
    .TEMP_REL  (TEMP_REL),
    .VDD_W     (VDD_W),
    .UV_LOCK   (UV_LOCK),
    .UV_RELEASE(UV_RELEASE)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .oc_flag  (oc_flag),
    .temp_code(temp_code),
    .vdd_code (vdd_code),
    .en_rst   (en_rst),
    .allow    (allow),
    .tsd      (tsd),
    .uvlo     (uvlo),
    .fault    (fault)
);

// File: tb/prot_fault_supervisor_tb_top.sv
module prot_fault_supervisor_tb_top;
    localparam int CLK_PERIOD = 20;
    localparam int TRIP = 2000 / CLK_PERIOD;
    localparam int T_SET = 165;
    localparam int T_REL = 155;
    localparam int V_LOCK = 76;
    localparam int V_REL = 86;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] oc_flag = '0;
    logic [7:0] temp_code = 8'd100;
    logic [7:0] vdd_code = 8'd100;
    logic       en_rst = 1'b0;
    logic [7:0] allow;
    logic       tsd;
    logic       uvlo;
    logic [7:0] fault;

    int n_tests = 0;
    int n_fail = 0;

    int       m_cnt [8];
    bit [7:0] m_flt = '0;
    bit       m_tsd = 1'b0;
    bit       m_uv = 1'b1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prot_fault_supervisor dut_i (
        .clk      (clk),
        .rst      (rst),
        .oc_flag  (oc_flag),
        .temp_code(temp_code),
        .vdd_code (vdd_code),
        .en_rst   (en_rst),
        .allow    (allow),
        .tsd      (tsd),
        .uvlo     (uvlo),
        .fault    (fault)
    );

    function automatic bit [7:0] exp_allow();
        return ~m_flt & {8{~m_tsd & ~m_uv & ~en_rst}};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic model_step();
        if (rst) begin
            m_flt = '0; m_tsd = 0; m_uv = 1;
            for (int i = 0; i < 8; i++) m_cnt[i] = 0;
        end else begin
            for (int i = 0; i < 8; i++) begin
                if (en_rst) begin
                    m_cnt[i] = 0; m_flt[i] = 0;
                end else if (oc_flag[i]) begin
                    if (m_cnt[i] == TRIP - 1) m_flt[i] = 1;
                    if (m_cnt[i] < TRIP - 1) m_cnt[i]++;
                end else begin
                    m_cnt[i] = 0;
                end
            end
            if (temp_code > T_SET) m_tsd = 1;
            else if (temp_code <= T_REL) m_tsd = 0;
            if (vdd_code < V_LOCK) m_uv = 1;
            else if (vdd_code > V_REL) m_uv = 0;
        end
    endtask

    // Apply inputs at a falling edge, step over one rising edge, compare at the next falling edge
    task automatic cyc(input bit [7:0] o, input bit [7:0] t, input bit [7:0] v, input bit e);
        oc_flag = o; temp_code = t; vdd_code = v; en_rst = e;
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(fault == m_flt, "R5", "fault", fault, m_flt);
        chk(tsd == m_tsd, "R7", "tsd", tsd, m_tsd);
        chk(uvlo == m_uv, "R8", "uvlo", uvlo, m_uv);
        chk(allow == exp_allow(), "R9", "allow", allow, exp_allow());
    endtask

    task automatic pulse(input int ch, input int len);
        for (int k = 0; k < len; k++) cyc(8'(1 << ch), 8'd100, 8'd100, 1'b0);
        cyc(8'h00, 8'd100, 8'd100, 1'b0);
    endtask

    initial begin
        bit [7:0] ro;
        int rt, rv, erun;
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        rst = 1;
        for (int k = 0; k < 3; k++) cyc(8'h00, 8'd100, 8'd70, 1'b0);
        // R1
        chk(uvlo === 1'b1 && tsd === 1'b0, "R1", "uvlo/tsd", {uvlo, tsd}, 2'b10);
        chk(fault === 8'h00 && allow === 8'h00, "R1", "fault/allow", {fault, allow}, 16'h0);
        rst = 0;
        cyc(8'h00, 8'd100, 8'd70, 1'b0);
        chk(uvlo === 1'b1, "R1", "uvlo after reset", uvlo, 1);

        // R8 rising and falling ramps
        for (int c = 70; c <= 95; c++) begin
            cyc(8'h00, 8'd100, 8'(c), 1'b0);
            if (c == V_REL)     chk(uvlo === 1'b1, "R8", "uvlo at upper code", uvlo, 1);
            if (c == V_REL + 1) chk(uvlo === 1'b0, "R8", "uvlo above upper code", uvlo, 0);
        end
        for (int c = 95; c >= 70; c--) begin
            cyc(8'h00, 8'd100, 8'(c), 1'b0);
            if (c == V_LOCK)     chk(uvlo === 1'b0, "R8", "uvlo at lower code", uvlo, 0);
            if (c == V_LOCK - 1) chk(uvlo === 1'b1, "R8", "uvlo below lower code", uvlo, 1);
        end
        cyc(8'h00, 8'd100, 8'd100, 1'b0);
        chk(allow === 8'hFF, "R9", "allow after release", allow, 8'hFF);

        // R7 thermal band
        cyc(8'h00, 8'(T_SET), 8'd100, 1'b0);
        chk(tsd === 1'b0, "R7", "tsd at trip code", tsd, 0);
        cyc(8'h00, 8'(T_SET + 1), 8'd100, 1'b0);
        chk(tsd === 1'b1 && allow === 8'h00, "R7", "tsd/allow above trip", {tsd, allow}, 9'h100);
        cyc(8'h00, 8'd160, 8'd100, 1'b0);
        cyc(8'h00, 8'(T_REL + 1), 8'd100, 1'b0);
        chk(tsd === 1'b1, "R7", "tsd held in band", tsd, 1);
        cyc(8'h00, 8'(T_REL), 8'd100, 1'b0);
        chk(tsd === 1'b0, "R7", "tsd released at lower code", tsd, 0);

        // R2 short pulses
        pulse(2, 95);
        chk(fault === 8'h00, "R2", "1.9us pulse", fault, 0);
        pulse(2, TRIP - 1);
        chk(fault === 8'h00, "R2", "one sample short", fault, 0);
        // R4 split pulse
        for (int k = 0; k < 60; k++) cyc(8'h04, 8'd100, 8'd100, 1'b0);
        cyc(8'h00, 8'd100, 8'd100, 1'b0);
        pulse(2, 60);
        chk(fault === 8'h00, "R4", "split pulse", fault, 0);
        // R3 trip
        pulse(2, 105);
        chk(fault === 8'h04, "R3", "2.1us pulse", fault, 8'h04);
        chk(allow === 8'hFB, "R9", "only channel 2 off", allow, 8'hFB);
        for (int k = 0; k < TRIP - 1; k++) cyc(8'h20, 8'd100, 8'd100, 1'b0);
        chk(fault === 8'h04, "R3", "channel 5 before last sample", fault, 8'h04);
        cyc(8'h20, 8'd100, 8'd100, 1'b0);
        chk(fault === 8'h24, "R3", "channel 5 exact count", fault, 8'h24);
        for (int k = 0; k < 20; k++) cyc(8'h00, 8'd100, 8'd100, 1'b0);
        chk(fault === 8'h24, "R5", "faults held", fault, 8'h24);

        // R6 pin pulse
        cyc(8'h00, 8'd100, 8'd100, 1'b1);
        chk(fault === 8'h00 && allow === 8'h00, "R6", "during pin high", {fault, allow}, 0);
        cyc(8'h00, 8'd100, 8'd100, 1'b0);
        chk(allow === 8'hFF, "R6", "after pin low", allow, 8'hFF);
        for (int k = 0; k < 150; k++) cyc(8'h01, 8'd100, 8'd100, 1'b1);
        chk(fault === 8'h00, "R6", "no trip while pin high", fault, 0);
        for (int k = 0; k < TRIP - 1; k++) cyc(8'h01, 8'd100, 8'd100, 1'b0);
        chk(fault === 8'h00, "R6", "count restarts after pin", fault, 0);
        cyc(8'h01, 8'd100, 8'd100, 1'b0);
        chk(fault === 8'h01, "R6", "trip after fresh count", fault, 8'h01);
        cyc(8'h00, 8'd100, 8'd100, 1'b1);

        // Random phase
        ro = '0; rt = 120; rv = 90; erun = 0;
        for (int k = 0; k < 5000; k++) begin
            for (int i = 0; i < 8; i++) if ($urandom_range(0, 79) == 0) ro[i] = ~ro[i];
            rt = rt + int'($urandom_range(0, 4)) - 2;
            if (rt < 140) rt = 140;
            if (rt > 175) rt = 175;
            rv = rv + int'($urandom_range(0, 4)) - 2;
            if (rv < 68) rv = 68;
            if (rv > 96) rv = 96;
            if (erun > 0) erun--;
            else if ($urandom_range(0, 299) == 0) erun = int'($urandom_range(1, 3));
            cyc(ro, 8'(rt), 8'(rv), erun > 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule